// File: doc/BRIEF.md
# Rotation Control Generator for an Inverse Butterfly Network

This block turns a rotation amount and a direction into the full set of switch controls for an N-bit inverse butterfly network. The network has lg(N) stages of N/2 two-input switches. With the controls this block produces, the network rotates its data word by the requested amount. The controls are built from a closed-form rule for each stage, with no table indexed by the amount.

Stage j works on sub-networks 2^j bits wide and uses the partial amount r = s mod 2^j. Its 2^(j-1)-bit switch pattern is a run of ones and zeros. That run is complemented once r reaches half of the sub-network width. The same pattern is then copied into every sub-network of that stage.

A left rotate is handled by converting it to a right rotate by (N - s) mod N. The request is sampled on a valid strobe, and the control vector is held in an output register until the next request.

Top module: `rotctl_gen`

## Requirements
- R1: The control vector layout is fixed. Stage j (1..lg N) occupies bits [(j-1)*N/2 +: N/2]. Switch k of stage j pairs data bit lo = (k / 2^(j-1))*2^j + (k mod 2^(j-1)) with data bit lo + 2^(j-1). A control bit of 1 swaps the pair and 0 passes it.
- R2: With rotLeft = 0 and amount s, the controlled network gives out[i] = in[(i+s) mod N] for every i.
- R3: With rotLeft = 1 and amount s, the controlled network gives out[i] = in[(i-s) mod N]. This equals a right rotate by (N-s) mod N.
- R4: For stage j, let m = 2^j, h = m/2 and r = (effective right amount) mod m. If r < h, switch t of each sub-network (t = 0..h-1) swaps exactly when t >= h-r. For N = 8 and right amount 1, the controls are 12'h8AF. For right amount 2, they are 12'hCF0.
- R5: If r >= h, switch t swaps exactly when t < m-r. For N = 8, right amount 5 gives 12'h7AF, amount 4 gives 12'hF00 and amount 7 gives 12'h15F.
- R6: Within a stage, every h-bit sub-network group carries an identical pattern.
- R7: A request presented with inValid high appears on ctrlBits one clock later, with ctrlValid high in that cycle.
- R8: While inValid is low, ctrlBits holds its value and ctrlValid is low one clock later, whatever rotAmt and rotLeft do.
- R9: While rst_n is low (active-low, asynchronous), ctrlBits is all zeros (the identity setting) and ctrlValid is low.
- R10: An amount of zero produces an all-zero control vector in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe; samples rotLeft and rotAmt |
| rotLeft | input | 1 | 1 = left rotate, 0 = right rotate |
| rotAmt | input | lg(N) | Rotation amount, 0..N-1 |
| ctrlValid | output | 1 | High one cycle after an accepted request |
| ctrlBits | output | (N/2)*lg(N) | Switch controls, stage 1 in the low bits |

## Verification
The hardest case is the complement branch in the low stages. For the wide instance, the partial amount crosses half the sub-network width at a different amount in each stage. A stage-level error only shows up for a few amounts, and only after it has passed through all later stages. The bench therefore sends every amount in both directions through a behavioural model of the network, using several random data words, and compares the result with a directly computed rotation. Hand-derived vectors for the 8-bit case pin down the exact patterns on both sides of each stage's switch-over point.

// File: rtl/rotctl_pkg.sv
package rotctl_pkg;
  // Strobes passed from the sequencing logic to the pattern datapath.
  typedef struct packed {
    logic load;    // capture a new control vector
    logic negate;  // convert a left amount to its right equivalent
  } rotStrobe_t;
endpackage

// File: rtl/rotctl_seq.sv
module rotctl_seq
  import rotctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       rotLeft,
  output rotStrobe_t strobe,
  output logic       ctrlValid
);
  always_comb begin
    strobe.load   = inValid;
    strobe.negate = rotLeft;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrlValid <= 1'b0;
    else        ctrlValid <= inValid;
  end
endmodule

// File: rtl/rotctl_path.sv
module rotctl_path
  import rotctl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  rotStrobe_t                    strobe,
  input  logic [$clog2(N)-1:0]          rotAmt,
  output logic [(N/2)*$clog2(N)-1:0]    ctrlBits
);
  localparam int LG   = $clog2(N);
  localparam int HALF = N / 2;
  localparam int CW   = HALF * LG;

  logic [LG-1:0] effAmt;
  logic [CW-1:0] nextBits;

  // Left rotate by s is a right rotate by (N - s) mod N.
  always_comb begin
    effAmt = strobe.negate ? (~rotAmt + 1'b1) : rotAmt;
  end

  for (genvar j = 1; j <= LG; j++) begin : g_stage
    localparam int M = 1 << j;
    localparam int H = M / 2;
    logic [H-1:0] basePat;

    // Thermometer pattern, complemented once r reaches H.
    always_comb begin
      int r;
      r = int'(effAmt) % M;
      for (int t = 0; t < H; t++) begin
        if (r < H) basePat[t] = (t >= H - r);
        else       basePat[t] = (t < M - r);
      end
    end

    // Same pattern in every sub-network of this stage.
    for (genvar g = 0; g < HALF / H; g++) begin : g_grp
      assign nextBits[(j-1)*HALF + g*H +: H] = basePat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctrlBits <= '0;
    else if (strobe.load) ctrlBits <= nextBits;
  end
endmodule

// File: rtl/rotctl_gen.sv
module rotctl_gen
  import rotctl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inValid,
  input  logic                          rotLeft,
  input  logic [$clog2(N)-1:0]          rotAmt,
  output logic                          ctrlValid,
  output logic [(N/2)*$clog2(N)-1:0]    ctrlBits
);
  rotStrobe_t strobe;

  rotctl_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .rotLeft   (rotLeft),
    .strobe    (strobe),
    .ctrlValid (ctrlValid)
  );

  rotctl_path #(.N(N)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .rotAmt   (rotAmt),
    .ctrlBits (ctrlBits)
  );
endmodule

// File: rtl/rotctl_gen_chk.sv
module rotctl_gen_chk #(
  parameter int N = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       inValid,
  input logic                       rotLeft,
  input logic [$clog2(N)-1:0]       rotAmt,
  input logic                       ctrlValid,
  input logic [(N/2)*$clog2(N)-1:0] ctrlBits
);
  localparam int LG   = $clog2(N);
  localparam int HALF = N / 2;
  localparam int CW   = HALF * LG;

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> ctrlValid);

  // R8
  idle_valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !ctrlValid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(ctrlBits));

  // R10
  zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && rotAmt == '0) |=> (ctrlBits == '0));

  // R5
  half_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && rotAmt == LG'(HALF)) |=>
      (ctrlBits == ({{(CW-HALF){1'b0}}, {HALF{1'b1}}} << ((LG-1)*HALF))));

  // R4
  stage_one_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (ctrlBits[HALF-1:0] ==
      ($past(rotAmt[0]) ? {HALF{1'b1}} : {HALF{1'b0}})));
endmodule

bind rotctl_gen rotctl_gen_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .rotLeft   (rotLeft),
  .rotAmt    (rotAmt),
  .ctrlValid (ctrlValid),
  .ctrlBits  (ctrlBits)
);

// File: tb/rotctl_gen_bench.sv
`timescale 1ns/1ps
module rotctl_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Narrow instance, N = 8
  logic        nValid = 1'b0, nLeft = 1'b0;
  logic [2:0]  nAmt = '0;
  logic        nOutValid;
  logic [11:0] nBits;

  // Wide instance, N = 64
  logic         wValid = 1'b0, wLeft = 1'b0;
  logic [5:0]   wAmt = '0;
  logic         wOutValid;
  logic [191:0] wBits;

  rotctl_gen #(.N(8)) u_rotctl_gen (
    .clk(clk), .rst_n(rst_n), .inValid(nValid), .rotLeft(nLeft),
    .rotAmt(nAmt), .ctrlValid(nOutValid), .ctrlBits(nBits));

  rotctl_gen #(.N(64)) u_rotctl_gen_wide (
    .clk(clk), .rst_n(rst_n), .inValid(wValid), .rotLeft(wLeft),
    .rotAmt(wAmt), .ctrlValid(wOutValid), .ctrlBits(wBits));

  int compared = 0;
  int mismatched = 0;

  // {left, amount, expected controls} for N = 8
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 3'd1, 12'h8AF},
    {1'b0, 3'd2, 12'hCF0},
    {1'b0, 3'd4, 12'hF00},
    {1'b0, 3'd5, 12'h7AF},
    {1'b0, 3'd7, 12'h15F},
    {1'b1, 3'd3, 12'h7AF},
    {1'b1, 3'd1, 12'h15F},
    {1'b1, 3'd4, 12'hF00}
  };

  task automatic check(input bit ok, input string req,
                       input logic [191:0] act, input logic [191:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural inverse butterfly network, R1 ordering
  function automatic logic [63:0] netModel(input logic [63:0] d,
      input logic [191:0] c, input int n);
    logic [63:0] x;
    int lg;
    x = d;
    lg = $clog2(n);
    for (int j = 1; j <= lg; j++) begin
      int h;
      h = 1 << (j - 1);
      for (int k = 0; k < n/2; k++) begin
        int lo;
        lo = (k / h) * 2 * h + (k % h);
        if (c[(j-1)*(n/2) + k]) begin
          logic tmp;
          tmp = x[lo]; x[lo] = x[lo+h]; x[lo+h] = tmp;
        end
      end
    end
    return x;
  endfunction

  function automatic logic [63:0] rotModel(input logic [63:0] d, input int s,
      input bit left, input int n);
    logic [63:0] o;
    o = '0;
    for (int i = 0; i < n; i++)
      o[i] = left ? d[(i - s + n) % n] : d[(i + s) % n];
    return o;
  endfunction

  task automatic applyN(input logic l, input logic [2:0] s);
    @(negedge clk); nValid = 1'b1; nLeft = l; nAmt = s;
    @(negedge clk); nValid = 1'b0;
  endtask

  task automatic applyW(input logic l, input logic [5:0] s);
    @(negedge clk); wValid = 1'b1; wLeft = l; wAmt = s;
    @(negedge clk); wValid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check(nBits == '0 && !nOutValid, "R9 reset narrow", {180'b0, nBits}, '0);
    check(wBits == '0 && !wOutValid, "R9 reset wide", wBits, '0);
    rst_n = 1'b1;

    // Hand-derived vectors (R4, R5, R3)
    for (int v = 0; v < 8; v++) begin
      applyN(VEC[v][15], VEC[v][14:12]);
      check(nBits == VEC[v][11:0], "R4/R5 vector", {180'b0, nBits}, {180'b0, VEC[v][11:0]});
      check(nOutValid == 1'b1, "R7 valid", {191'b0, nOutValid}, 192'd1);
    end

    // R8 hold while idle
    begin
      logic [11:0] held;
      held = nBits;
      @(negedge clk); nAmt = 3'd6; nLeft = 1'b1;
      @(negedge clk);
      check(nBits == held, "R8 hold", {180'b0, nBits}, {180'b0, held});
      check(!nOutValid, "R8 valid low", {191'b0, nOutValid}, '0);
    end

    // R10 zero amount, both directions
    for (int l = 0; l < 2; l++) begin
      applyN(l[0], 3'd0);
      check(nBits == '0, "R10 zero narrow", {180'b0, nBits}, '0);
      applyW(l[0], 6'd0);
      check(wBits == '0, "R10 zero wide", wBits, '0);
    end

    // R1 R2 R3: every amount, both directions, through the network model
    for (int l = 0; l < 2; l++) begin
      for (int s = 0; s < 8; s++) begin
        applyN(l[0], 3'(s));
        for (int r = 0; r < 3; r++) begin
          logic [63:0] d, got, exp;
          d = {56'b0, 8'($urandom)};
          got = netModel(d, {180'b0, nBits}, 8);
          exp = rotModel(d, s, l[0], 8);
          check(got == exp, l ? "R3 R1 narrow rotate" : "R2 R1 narrow rotate",
                {128'b0, got}, {128'b0, exp});
        end
      end
      for (int s = 0; s < 64; s++) begin
        applyW(l[0], 6'(s));
        for (int r = 0; r < 3; r++) begin
          logic [63:0] d, got, exp;
          d = {$urandom, $urandom};
          got = netModel(d, wBits, 64);
          exp = rotModel(d, s, l[0], 64);
          check(got == exp, l ? "R3 R1 wide rotate" : "R2 R1 wide rotate",
                {128'b0, got}, {128'b0, exp});
        end
        // R6 identical groups in each stage
        for (int j = 1; j <= 6; j++) begin
          int h;
          h = 1 << (j - 1);
          for (int g = 1; g < 32 / h; g++) begin
            logic [31:0] a, b;
            a = '0; b = '0;
            for (int t = 0; t < h; t++) begin
              a[t] = wBits[(j-1)*32 + t];
              b[t] = wBits[(j-1)*32 + g*h + t];
            end
            check(a == b, "R6 group pattern", {160'b0, b}, {160'b0, a});
          end
        end
      end
    end

    // R9 reset after activity
    applyN(1'b0, 3'd5);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(nBits == '0 && !nOutValid, "R9 reset after load", {180'b0, nBits}, '0);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule